// File: doc/BRIEF.md
# Half-duplex echo-checked frame transmitter

This block sends a short message of 8-bit frames onto a serial line that several nodes share, one talker at a time. A message is written into a small internal store one byte per cycle through a valid/ready handshake. The block then enables the tri-state line driver (active-low enable) and shifts the frames out. Each frame has a low start bit, eight data bits least significant first and a high stop bit. Every bit lasts a programmable number of clock cycles. The first frame of a message is marked as an address by forcing its top bit to 1. The frames that follow are marked as data by forcing their top bit to 0.

The transmitter's own output comes back through the receiver as a local echo. The block samples the echo in the middle of every bit and compares it with the bit it drove. If any bit of a frame differs, another node has driven the line at the same time. At the end of that frame's stop bit the block releases the driver and waits a pseudo-random whole number of frame times. It then sends the whole message again from the first frame. After a configurable number of retries it gives up and signals an error.

Top module: `hdx_echo_tx`

## Requirements
- R1: `tx_en_n` is 0 for every cycle of a transmission attempt and 1 at all other times (idle and back-off).
- R2: Each frame is one start bit (0), then data bits 0 to 7 in that order (LSB first), then one stop bit (1). Each bit lasts exactly `bit_div` cycles (`bit_div` >= 4). `tx_line` is 1 whenever `tx_en_n` is 1.
- R3: Bit 7 of frame 0 of a message is sent as 1. Bit 7 of every later frame is sent as 0. Bits 6..0 are sent as written.
- R4: A byte is accepted on a cycle where `in_valid` and `in_ready` are both 1. The message ends with the byte that carries `in_last`, or with the DEPTH-th byte, whichever comes first. From the next cycle `in_ready` is 0 until the message completes or is abandoned, and `in_valid` has no effect during that time.
- R5: The echo on `rx_line` is sampled at cycle `bit_div/2` of each bit. Any mismatch in a frame makes the attempt end at the close of that frame's stop bit: a failed attempt that collides in frame 0 keeps `tx_en_n` low for exactly 10*`bit_div` cycles.
- R6: After a collision that is not the last allowed one, `tx_en_n` stays 1 for k*10*`bit_div` cycles, with k between 1 and 2^BO_W (8 by default) taken from a 16-bit LFSR. The next attempt then restarts at frame 0.
- R7: When the last frame's stop bit ends and the attempt had no mismatch, `done` is 1 for exactly one cycle. That cycle is the first cycle with `tx_en_n` = 1, and `in_ready` is 1 in that cycle.
- R8: A collision on an attempt taken after `max_retry` retries pulses `err` for one cycle, in the first released cycle. No further attempt follows, and the block returns to accepting bytes.
- R9: During and right after reset, `tx_line` = 1, `tx_en_n` = 1, `in_ready` = 1, `done` = 0 and `err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_data | input | 8 | Message byte |
| in_last | input | 1 | Offered byte closes the message |
| in_ready | output | 1 | Block is accepting message bytes |
| bit_div | input | DIV_W | Clock cycles per serial bit (>= 4) |
| max_retry | input | RETRY_W | Retries allowed before the message is abandoned |
| rx_line | input | 1 | Receive path, carrying the echo of the line |
| tx_line | output | 1 | Serial transmit data, idle high |
| tx_en_n | output | 1 | Active-low enable for the tri-state line driver |
| done | output | 1 | One-cycle pulse: message sent without collision |
| err | output | 1 | One-cycle pulse: message abandoned after retries |

## Verification
The assertions assume that `bit_div` is at least 4 and that `bit_div` and `max_retry` do not change while a message is in flight. They also assume that `rx_line` is held high whenever the driver is released. The bench programs both settings only while the block is idle, uses 4 and 5 cycles per bit, and models the echo as the driven line. During attempts marked for collision it drives the echo inverted. Every mid-bit sample and every back-off length is checked against timing computed from `bit_div`. The LFSR value is never predicted: the bench only requires whole frame times within the allowed range.

// File: rtl/hdx_echo_tx.sv
module hdx_echo_tx #(
  parameter int DEPTH   = 8,
  parameter int DIV_W   = 8,
  parameter int RETRY_W = 4,
  parameter int BO_W    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [7:0]         in_data,
  input  logic               in_last,
  output logic               in_ready,
  input  logic [DIV_W-1:0]   bit_div,
  input  logic [RETRY_W-1:0] max_retry,
  input  logic               rx_line,
  output logic               tx_line,
  output logic               tx_en_n,
  output logic               done,
  output logic               err
);
  localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int BCW = BO_W + 5;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT} state_t;

  state_t             state_q;
  logic [7:0]         store_q [DEPTH];
  logic [IW-1:0]      wr_q, last_q, idx_q;
  logic [DIV_W-1:0]   cyc_q;
  logic [BCW-1:0]     bit_q;
  logic [RETRY_W-1:0] tries_q;
  logic [15:0]        lfsr_q;
  logic               mism_q, done_q, err_q;
  logic               tx_bit;

  wire         tick    = cyc_q == bit_div - DIV_W'(1);
  wire         sample  = cyc_q == (bit_div >> 1);
  wire [7:0]   cur     = store_q[idx_q];
  wire         bad     = sample && (rx_line != tx_bit);
  wire         collide = mism_q | bad;
  wire [BCW-1:0] bo_len = BCW'(lfsr_q[BO_W-1:0]) * BCW'(10) + BCW'(10);
  wire         accept  = in_valid && state_q == S_IDLE;

  always_comb begin
    if (bit_q == BCW'(0))      tx_bit = 1'b0;
    else if (bit_q == BCW'(9)) tx_bit = 1'b1;
    else                       tx_bit = cur[3'(bit_q - BCW'(1))];
  end

  assign in_ready = state_q == S_IDLE;
  assign tx_en_n  = state_q != S_SEND;
  assign tx_line  = (state_q == S_SEND) ? tx_bit : 1'b1;
  assign done     = done_q;
  assign err      = err_q;

  always_ff @(posedge clk)
    if (accept) store_q[wr_q] <= {wr_q == IW'(0), in_data[6:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      wr_q    <= '0;
      last_q  <= '0;
      idx_q   <= '0;
      cyc_q   <= '0;
      bit_q   <= '0;
      tries_q <= '0;
      mism_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      lfsr_q  <= 16'hACE1;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      lfsr_q <= {1'b0, lfsr_q[15:1]} ^ (lfsr_q[0] ? 16'hB400 : 16'h0000);
      case (state_q)
        S_IDLE: if (in_valid) begin
          wr_q <= wr_q + IW'(1);
          if (in_last || wr_q == IW'(DEPTH - 1)) begin
            last_q  <= wr_q;
            wr_q    <= '0;
            idx_q   <= '0;
            cyc_q   <= '0;
            bit_q   <= '0;
            mism_q  <= 1'b0;
            tries_q <= '0;
            state_q <= S_SEND;
          end
        end
        S_SEND: begin
          cyc_q  <= tick ? '0 : cyc_q + DIV_W'(1);
          mism_q <= collide;
          if (tick) begin
            if (bit_q == BCW'(9)) begin
              mism_q <= 1'b0;
              bit_q  <= '0;
              if (collide) begin
                idx_q <= '0;
                if (tries_q == max_retry) begin
                  err_q   <= 1'b1;
                  state_q <= S_IDLE;
                end else begin
                  tries_q <= tries_q + RETRY_W'(1);
                  bit_q   <= bo_len;
                  state_q <= S_WAIT;
                end
              end else if (idx_q == last_q) begin
                done_q  <= 1'b1;
                idx_q   <= '0;
                state_q <= S_IDLE;
              end else begin
                idx_q <= idx_q + IW'(1);
              end
            end else begin
              bit_q <= bit_q + BCW'(1);
            end
          end
        end
        S_WAIT: begin
          cyc_q <= tick ? '0 : cyc_q + DIV_W'(1);
          if (tick) begin
            if (bit_q == BCW'(1)) begin
              bit_q   <= '0;
              mism_q  <= 1'b0;
              state_q <= S_SEND;
            end else begin
              bit_q <= bit_q - BCW'(1);
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

module hdx_echo_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic tx_line,
  input logic tx_en_n,
  input logic done,
  input logic err
);
  assert_released_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en_n |-> tx_line);
  assert_attempt_starts_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en_n) |-> !tx_line);
  assert_no_accept_while_driving_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> tx_en_n);
  assert_done_on_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($rose(tx_en_n) && in_ready));
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_err_on_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($rose(tx_en_n) && in_ready));
  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err}));
endmodule

bind hdx_echo_tx hdx_echo_tx_chk u_chk (.*);

// File: tb/hdx_echo_tx_test.sv
module hdx_echo_tx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_last = 1'b0, corrupt = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic [7:0] bit_div = 8'd4;
  logic [3:0] max_retry = 4'd2;
  logic       in_ready, tx_line, tx_en_n, done, err;
  wire        rx_line = tx_en_n ? 1'b1 : (tx_line ^ corrupt);

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] exp_q [8];

  hdx_echo_tx uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .bit_div(bit_div),
    .max_retry(max_retry), .rx_line(rx_line), .tx_line(tx_line),
    .tx_en_n(tx_en_n), .done(done), .err(err));

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 180000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 180000);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_msg(input int len, input int div, input int coll, input int mr, input bit use_last);
    int a, n, g, fr;
    bit en_ok, rdy_ok;
    @(negedge clk);
    bit_div = 8'(div);
    max_retry = 4'(mr);
    for (int i = 0; i < len; i++) begin
      logic [7:0] p;
      p = 8'(i * 53 + len * 29 + div * 7 + coll);
      exp_q[i] = (i == 0) ? (p | 8'h80) : (p & 8'h7F);
      in_valid = 1'b1;
      in_data = p;
      in_last = use_last && (i == len - 1);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last = 1'b0;
    corrupt = coll > 0;
    fr = 10 * div;
    check(!in_ready, "R4 ready low after message", in_ready, 0);
    check(!tx_en_n, "R1 driver enabled at attempt start", tx_en_n, 0);
    a = 0;
    forever begin
      if (corrupt) begin
        n = 0;
        while (!tx_en_n && n < 100000) begin n++; @(negedge clk); end
        check(n == fr, "R5 collided attempt length", n, fr);
        if (a == mr) begin
          check(err && !done, "R8 err pulse on final collision", err, 1);
          rdy_ok = 1'b1;
          for (int k = 0; k < 3 * fr; k++) begin
            @(negedge clk);
            if (!tx_en_n || !in_ready || err) rdy_ok = 1'b0;
          end
          check(rdy_ok, "R8 no retry after abandon", rdy_ok, 1);
          break;
        end
        check(!err && !done, "R6 no outcome on retried collision", err, 0);
        corrupt = (a + 1) < coll;
        g = 0;
        while (tx_en_n && g < 100000) begin g++; @(negedge clk); end
        check(g % fr == 0 && g / fr >= 1 && g / fr <= 8, "R6 back-off whole frames", g, fr);
        a++;
      end else begin
        in_valid = 1'b1;
        in_data = 8'hFF;
        in_last = 1'b1;
        en_ok = 1'b1;
        for (int k = 0; k < len * fr; k++) begin
          if (tx_en_n) en_ok = 1'b0;
          if (k % div == div / 2) begin
            int f, b;
            bit e;
            f = k / fr;
            b = (k / div) % 10;
            e = (b == 0) ? 1'b0 : (b == 9) ? 1'b1 : exp_q[f][b-1];
            check(tx_line == e, (b == 8) ? "R3 top bit marking" : "R2 frame bit", tx_line, e);
          end
          @(negedge clk);
        end
        in_valid = 1'b0;
        in_last = 1'b0;
        check(en_ok, "R1 enable held through attempt", en_ok, 1);
        check(tx_en_n && done && in_ready && !err, "R7 done at release", done, 1);
        @(negedge clk);
        check(!done && tx_line, "R7 done single cycle", done, 0);
        break;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(tx_line && tx_en_n && in_ready && !done && !err, "R9 reset state", tx_en_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_line && tx_en_n && in_ready && !done && !err, "R9 after reset", in_ready, 1);
    foreach (exp_q[i]) exp_q[i] = 8'h00;
    for (int d = 4; d <= 5; d++)
      for (int len = 1; len <= 5; len++)
        if (len != 4)
          for (int c = 0; c <= 3; c++)
            run_msg(len, d, c, 2, 1'b1);
    run_msg(8, 4, 0, 2, 1'b0);
    run_msg(8, 5, 1, 2, 1'b0);
    run_msg(2, 4, 1, 0, 1'b1);
    run_msg(2, 4, 0, 0, 1'b1);
    run_msg(3, 5, 4, 3, 1'b1);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule